// File: doc/BRIEF.md
# PCI Clock Stop Gate

This block drives a group of PCI-rate clock outputs from a source phase generated inside the same clock domain. The phase is a square wave made by dividing the system clock. A low level on an asynchronous stop request parks the gated outputs low. The request passes a multi-stage synchronizer first. Every start and every stop happens at a falling phase boundary, so no output ever shows a shortened high pulse. After a restart the outputs must emit a minimum number of full pulses before a new stop can take hold.

One free-running output follows the source phase and never responds to the stop request. Every output, the free-running one included, also has its own enable bit, and a cleared bit holds that output low. A mode strap is captured while reset is held and decides how a shared pin is used. In one mode the pin is the stop input. In the other mode the pin carries an SDRAM clock outward and the stop request is treated as permanently released.

Top module: `pci_stop_gate`

## Requirements
- R1: The stop request (low on `share_pin_in` in stop-input mode) passes a synchronizer and is sampled only at a source falling boundary. With default parameters, a request applied just after the free output rises in PCI period k is sampled at the fall of period k+1. A request that lasts a single period therefore removes exactly one pulse.
- R2: A stop that has been accepted holds every gated output low. With default parameters, a request applied in period k leaves period k+1 as a full pulse, and period k+2 onward is low.
- R3: When the request is released, the gated outputs resume with a full-width high phase. With default parameters, a release in period k gives the first pulse in period k+2.
- R4: After reset, or after a restart, the gated outputs emit at least MIN_RUN (default 10) full pulses before a held stop request takes effect.
- R5: `pci_free` keeps a period of 2*HALF_CYC system clocks, with a high phase of HALF_CYC clocks, whatever the stop request does.
- R6: Bit i of `out_en` enables `pci_out[i]` (1 runs the output, 0 holds it low), and `free_en` does the same for `pci_free`. A change is latched at the next source fall and applies from the following period.
- R7: Gate and enable state change only at the boundary where the source goes low. Every high pulse on a gated output therefore lines up exactly with a high phase of the free output.
- R8: `mode_strap` is captured while `rst_n` is low and ignored afterwards. A value of 1 makes the shared pin an output (`share_pin_oe`=1, `share_pin_out` follows `sdram_clk_in`) and ignores the stop request. A value of 0 makes the pin the stop input (`share_pin_oe`=0, `share_pin_out`=0).
- R9: While `rst_n` is low, every clock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the PCI phase is divided from it |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| mode_strap | input | 1 | Shared-pin function strap (1 = SDRAM clock output, 0 = stop input) |
| share_pin_in | input | 1 | Shared pin input level; active-low asynchronous stop request in mode 0 |
| sdram_clk_in | input | 1 | SDRAM clock routed to the shared pin in mode 1 |
| out_en | input | N_OUT | Per-output enables for the gated outputs |
| free_en | input | 1 | Enable for the free-running output |
| pci_out | output | N_OUT | Gated PCI clock outputs |
| pci_free | output | 1 | Free-running PCI clock output |
| share_pin_out | output | 1 | Shared pin output value |
| share_pin_oe | output | 1 | Shared pin output enable |

## Verification
The bench holds a stop request from reset onward. A design that let the request through at once, or that did not count the pulses from reset, would emit fewer than ten pulses. It then releases the request and asserts it again in the very next period, which catches a restart that does not clear the run count. A stop lasting a single period must remove exactly one pulse: a missing synchronizer stage shifts that pulse earlier, and a gate updated on the rising boundary shows up as a runt against the free output. Enable patterns are changed while the outputs run, and the strap is swept with the stop pin held low, to expose a mode that fails to mask the request.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic {
    GATE_PARK = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;

  // Width needed to hold values 0..n (at least one bit).
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pcs_phase_gen.sv
module pcs_phase_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last  = (cnt == LAST);
  assign rise_evt = at_last && !phase;
  assign fall_evt = at_last && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (at_last) begin
      cnt   <= '0;
      phase <= !phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcs_gate_ctrl.sv
module pcs_gate_ctrl
  import pcs_pkg::*;
#(
  parameter int MIN_RUN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic stop_req,
  output logic run_gate,
  output logic run_ok
);
  localparam int RW = cnt_bits(MIN_RUN);
  localparam logic [RW-1:0] RUN_MAX = RW'(MIN_RUN);

  gate_state_e   state;
  logic [RW-1:0] run_cnt;

  function automatic logic [RW-1:0] sat_inc(input logic [RW-1:0] v);
    return (v >= RUN_MAX) ? RUN_MAX : v + 1'b1;
  endfunction

  function automatic logic min_run_met(input logic [RW-1:0] v);
    return v >= RUN_MAX;
  endfunction

  assign run_gate = (state == GATE_RUN);
  assign run_ok   = min_run_met(run_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= GATE_RUN;
      run_cnt <= '0;
    end else if (fall_evt) begin
      if (run_gate && stop_req && run_ok) begin
        state <= GATE_PARK;
      end else if (!run_gate && !stop_req) begin
        state   <= GATE_RUN;
        run_cnt <= '0;
      end
    end else if (rise_evt && run_gate) begin
      run_cnt <= sat_inc(run_cnt);
    end
  end
endmodule

// File: rtl/pci_stop_gate.sv
module pci_stop_gate #(
  parameter int N_OUT       = 6,
  parameter int HALF_CYC    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RUN     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_strap,
  input  logic             share_pin_in,
  input  logic             sdram_clk_in,
  input  logic [N_OUT-1:0] out_en,
  input  logic             free_en,
  output logic [N_OUT-1:0] pci_out,
  output logic             pci_free,
  output logic             share_pin_out,
  output logic             share_pin_oe
);
  // Named internal events, observed by the bound checker.
  logic             src_phase;
  logic             rise_evt;
  logic             fall_evt;
  logic             pin_sync_n;
  logic             stop_sync;
  logic             stop_eff;
  logic             run_gate;
  logic             run_ok;
  logic             mode_q;
  logic [N_OUT-1:0] mask_q;
  logic             free_mask_q;

  // Strap capture: sampled on every clock while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_strap;
  end

  pcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (share_pin_in),
    .q_sync  (pin_sync_n)
  );

  assign stop_sync = !pin_sync_n;
  assign stop_eff  = stop_sync && !mode_q;

  pcs_phase_gen #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (src_phase),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  pcs_gate_ctrl #(.MIN_RUN(MIN_RUN)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .stop_req (stop_eff),
    .run_gate (run_gate),
    .run_ok   (run_ok)
  );

  // Enables latch only at a falling boundary; outputs are plain flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '1;
      free_mask_q <= 1'b1;
      pci_out     <= '0;
      pci_free    <= 1'b0;
    end else begin
      if (fall_evt) begin
        mask_q      <= out_en;
        free_mask_q <= free_en;
      end
      pci_out  <= {N_OUT{src_phase && run_gate}} & mask_q;
      pci_free <= src_phase && free_mask_q;
    end
  end

  assign share_pin_oe  = mode_q;
  assign share_pin_out = mode_q && sdram_clk_in;
endmodule

// File: rtl/pci_stop_gate_chk.sv
module pci_stop_gate_chk #(
  parameter int N_OUT    = 6,
  parameter int HALF_CYC = 2,
  parameter int MIN_RUN  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_phase,
  input logic             run_gate,
  input logic             stop_eff,
  input logic             mode_q,
  input logic [N_OUT-1:0] mask_q,
  input logic [N_OUT-1:0] pci_out
);
  localparam int SW = (MIN_RUN < 2) ? 1 : $clog2(MIN_RUN + 1);

  logic          gate_d;
  logic          phase_d;
  logic [SW-1:0] seen;

  // Full pulses seen since the last restart, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d  <= 1'b1;
      phase_d <= 1'b0;
      seen    <= '0;
    end else begin
      gate_d  <= run_gate;
      phase_d <= src_phase;
      if (run_gate && !gate_d) seen <= '0;
      else if (run_gate && src_phase && !phase_d && seen < SW'(MIN_RUN)) seen <= seen + 1'b1;
    end
  end

  p_park_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_gate |=> (pci_out == '0));

  p_min_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_gate && gate_d) |-> (seen >= SW'(MIN_RUN)));

  p_gate_low_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_gate) |-> !src_phase);

  p_mask_low_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_q) |-> !src_phase);

  p_mode_ignores_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !stop_eff);

  p_strap_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));

  for (genvar i = 0; i < N_OUT; i++) begin : g_runt
    if (HALF_CYC > 1) begin : g_wide
      p_no_runt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_out[i]) |=> pci_out[i]);
    end
  end
endmodule

bind pci_stop_gate pci_stop_gate_chk #(
  .N_OUT(N_OUT), .HALF_CYC(HALF_CYC), .MIN_RUN(MIN_RUN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_phase (src_phase),
  .run_gate  (run_gate),
  .stop_eff  (stop_eff),
  .mode_q    (mode_q),
  .mask_q    (mask_q),
  .pci_out   (pci_out)
);

// File: tb/pci_stop_gate_test.sv
module pci_stop_gate_test;
  localparam int N    = 6;
  localparam int MINR = 10;
  localparam int PER  = 4;   // 2 * HALF_CYC system clocks

  logic         clk = 1'b0, rst_n = 1'b0, mode_strap = 1'b0;
  logic         share_pin_in = 1'b0, sdram_clk_in = 1'b0, free_en = 1'b1;
  logic [N-1:0] out_en = '1;
  logic [N-1:0] pci_out;
  logic         pci_free, share_pin_out, share_pin_oe;

  always #5 clk = ~clk;

  pci_stop_gate #(.N_OUT(N), .HALF_CYC(2), .SYNC_STAGES(2), .MIN_RUN(MINR)) uut (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .share_pin_in(share_pin_in),
    .sdram_clk_in(sdram_clk_in), .out_en(out_en), .free_en(free_en),
    .pci_out(pci_out), .pci_free(pci_free), .share_pin_out(share_pin_out),
    .share_pin_oe(share_pin_oe)
  );

  int n_chk = 0, n_err = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct { int idx; logic [N-1:0] exp; string tag; } item_t;
  item_t sb[$];
  int per_idx = 0;
  always @(posedge pci_free) per_idx++;

  // Period-level model built from the requirements.
  bit           m_gate, m_mode, m_req_prev;
  int           m_runs;
  logic [N-1:0] m_mask;
  bit           mon_en = 1'b0;

  // Monitor: classifies each free-output period and compares against the scoreboard.
  initial begin : monitor
    bit started = 0, prev_f = 0;
    int len = 0, hi = 0;
    logic [N-1:0] all_hi = '1, lo_hit = '0, any_hi = '0, bad;
    item_t it;
    forever begin
      @(negedge clk);
      if (!mon_en) begin started = 0; prev_f = pci_free; continue; end
      if (pci_free && !prev_f) begin
        if (started) begin
          check(len == PER, "R5 free period length", len, PER);
          check(hi == PER/2, "R5 free high width", hi, PER/2);
          bad = '0;
          for (int i = 0; i < N; i++)
            bad[i] = !((all_hi[i] && !lo_hit[i]) || !any_hi[i]);
          check(bad == '0, "R7 pulse aligned to free phase", bad, 0);
          while (sb.size() > 0 && sb[0].idx < per_idx - 1) void'(sb.pop_front());
          if (sb.size() > 0 && sb[0].idx == per_idx - 1) begin
            it = sb.pop_front();
            check(any_hi == it.exp, it.tag, any_hi, it.exp);
          end
        end
        started = 1; len = 0; hi = 0; all_hi = '1; lo_hit = '0; any_hi = '0;
      end
      if (started) begin
        len++;
        if (pci_free) begin hi++; all_hi &= pci_out; end
        else lo_hit |= pci_out;
        any_hi |= pci_out;
      end
      prev_f = pci_free;
    end
  end

  // Driver: one call per PCI period; pushes the expectation, then applies stimulus.
  task automatic step(input bit stop_req, input logic [N-1:0] en, input string tag);
    int runs_after;
    @(posedge pci_free);
    @(negedge clk);
    sb.push_back('{per_idx, (m_gate ? m_mask : '0), tag});
    share_pin_in = !stop_req;
    out_en       = en;
    runs_after = m_gate ? ((m_runs < MINR) ? m_runs + 1 : m_runs) : m_runs;
    if (m_gate && m_req_prev && runs_after >= MINR) m_gate = 0;
    else if (!m_gate && !m_req_prev) begin m_gate = 1; runs_after = 0; end
    m_runs     = runs_after;
    m_req_prev = stop_req && !m_mode;
    m_mask     = en;
  endtask

  task automatic do_reset(input bit strap, input bit stop);
    mon_en = 0;
    sb.delete();
    @(negedge clk);
    rst_n = 0; mode_strap = strap; share_pin_in = !stop; out_en = '1; free_en = 1;
    repeat (4) @(negedge clk);
    check(pci_out == '0, "R9 gated low in reset", pci_out, 0);
    check(pci_free == 1'b0, "R9 free low in reset", pci_free, 0);
    check(share_pin_oe == strap, "R8 strap sets pin direction", share_pin_oe, strap);
    m_gate = 1; m_runs = 0; m_mode = strap; m_req_prev = stop && !strap; m_mask = '1;
    rst_n = 1; mon_en = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : main
    int hi_seen;
    // Stop held from reset: R4 ten pulses, then R2 parked.
    do_reset(1'b0, 1'b1);
    sdram_clk_in = 1; #1;
    check(share_pin_out == 1'b0, "R8 pin not driven in stop mode", share_pin_out, 0);
    sdram_clk_in = 0;
    for (int k = 0; k < 14; k++) step(1'b1, '1, "R4 min run from reset");
    // Release: R3 restart two periods later.
    for (int k = 0; k < 16; k++) step(1'b0, '1, "R3 restart after release");
    // Stop while long running: R2 latency.
    for (int k = 0; k < 5; k++) step(1'b1, '1, "R2 park after stop");
    // Release then request again at once: R4 after restart.
    step(1'b0, '1, "R3 release");
    for (int k = 0; k < 16; k++) step(1'b1, '1, "R4 min run after restart");
    for (int k = 0; k < 14; k++) step(1'b0, '1, "R3 run");
    // Per-output enables: R6.
    for (int k = 0; k < 3; k++) step(1'b0, 6'b101010, "R6 enable pattern a");
    for (int k = 0; k < 3; k++) step(1'b0, 6'b010101, "R6 enable pattern b");
    for (int k = 0; k < 2; k++) step(1'b0, '1, "R6 enable restore");
    // Single-period stop: R1 exactly one pulse removed.
    step(1'b1, '1, "R1 short request");
    for (int k = 0; k < 5; k++) step(1'b0, '1, "R1 short request effect");
    repeat (2) @(posedge pci_free);
    repeat (2) @(negedge clk);

    // Mode 1: stop pin ignored, SDRAM clock passed out: R8.
    do_reset(1'b1, 1'b1);
    mode_strap = 0;
    for (int k = 0; k < 14; k++) step(1'b1, '1, "R8 stop ignored in output mode");
    check(share_pin_oe == 1'b1, "R8 strap ignored after reset", share_pin_oe, 1);
    sdram_clk_in = 1; #1;
    check(share_pin_out == 1'b1, "R8 pin follows sdram clock high", share_pin_out, 1);
    sdram_clk_in = 0; #1;
    check(share_pin_out == 1'b0, "R8 pin follows sdram clock low", share_pin_out, 0);
    repeat (2) @(posedge pci_free);
    @(negedge clk);

    // Free-output enable: R6, gated outputs keep running: R5.
    mon_en = 0;
    free_en = 0;
    repeat (12) @(negedge clk);
    hi_seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(pci_free == 1'b0, "R6 free output disabled", pci_free, 0);
      if (pci_out != '0) hi_seen++;
    end
    check(hi_seen == 4, "R5 gated outputs unaffected by free enable", hi_seen, 4);
    finish_run();
  end
endmodule